// File: doc/BRIEF.md
# Two-Branch Fetch Run Selector

This block sits in the front end of a wide core, between the instruction-cache read and the fetch queue. Each cycle it is handed one cache line's worth of predecode flags plus the branch predictions for that line, and it decides how many consecutive instruction slots, counted from the fetch address, go forward to decode. It also decides where fetch goes next. Two predictions are consumed per cycle. The first branch met in the run gets only a direction guess: when that guess is not-taken, the run carries on past it. The second branch met always closes the run and carries the full prediction.

Runs stop at the earliest of three points: the configured slot cap, the last slot of the line, or the closing branch. The redirect address is chosen in a fixed order. A return that has a valid link-stack entry takes the link-stack address. Otherwise a target-buffer hit takes the buffered target. Otherwise fetch continues sequentially. Results are registered and appear one cycle after the request.

Top module: `fetch_run_sel`

## Requirements
- R1: While reset is asserted, and at the first sample after it, out_valid is 0 and out_mask, out_count and out_next_addr are all zero.
- R2: A request with req_valid high gives out_valid high, with its results, exactly one clock later. A cycle without a request gives out_valid low, and out_mask, out_count and out_next_addr keep their previous values.
- R3: With no branch at or after the start slot, out_count equals the smaller of the effective cap and the number of slots from the start slot to the end of the line. The start slot is fetch_addr bits [5:2] with the defaults (16 slots of 4 bytes). out_next_addr is then the sequential address: fetch_addr with bits [1:0] cleared, plus 4 times out_count, modulo 2^32.
- R4: The effective cap is max_run when max_run is between 1 and MAX_RUN (12). When max_run is 0 or greater than MAX_RUN, the cap is MAX_RUN.
- R5: A first branch that is conditional (pd_branch set, pd_uncond and pd_return clear) with dir1_taken low does not end the run.
- R6: A first branch that is predicted taken ends the run with its own slot included. Predicted taken means dir1_taken high, or pd_uncond set, or pd_return set.
- R7: The second branch in the run always ends the run with its own slot included. It redirects only when pred2_taken is high, or when it is unconditional or a return. Otherwise out_next_addr is the sequential address after it.
- R8: On a redirect, out_next_addr is ras_addr when the closing branch is a return and ras_valid is high. Otherwise it is btb_target when btb_hit is high.
- R9: A taken closing branch whose target lookup misses still ends the run at its slot, and out_next_addr falls back to the sequential address after that slot.
- R10: A branch that lies before the start slot, or outside the slots the cap and the line allow, has no effect on out_count or out_next_addr.
- R11: out_mask has a single contiguous run of ones, beginning at the start slot, and its population count equals out_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A line and its predictions are presented this cycle |
| fetch_addr | input | 32 | Byte address of the first instruction to fetch |
| pd_branch | input | 16 | Predecode: slot holds a conditional branch |
| pd_uncond | input | 16 | Predecode: slot holds a jump or call, always taken |
| pd_return | input | 16 | Predecode: slot holds a return, always taken |
| max_run | input | 4 | Configured slot cap (0 or above 12 means 12) |
| dir1_taken | input | 1 | Direction guess for the first branch in the run |
| pred2_taken | input | 1 | Taken guess for the second branch in the run |
| btb_hit | input | 1 | Target buffer holds a target for the closing branch |
| btb_target | input | 32 | Target from the target buffer |
| ras_valid | input | 1 | Link stack has a valid top entry |
| ras_addr | input | 32 | Return address at the top of the link stack |
| out_valid | output | 1 | Registered results are valid |
| out_mask | output | 16 | Slots of the line that are sent to decode |
| out_count | output | 4 | Number of slots sent |
| out_next_addr | output | 32 | Address of the next fetch |

## Verification
The hardest case to reach is a return that is the second branch of its run. It has to sit behind a not-taken conditional branch, inside the cap, and before the end of the line, and it must be presented while the target buffer also hits, so that the link-stack priority is actually tested. Random predecode masks seldom line up this way, so directed lines place the two branches at chosen slots. Those lines also sweep the start offset and the cap so that the closing branch lands just inside and just outside the run. A random phase then covers the rest, with each cycle compared against a behavioural slot-walking model.

// File: rtl/frs_pkg.sv
package frs_pkg;
  // Source of the next fetch address, in priority order (highest last).
  typedef enum logic [1:0] {
    NXT_SEQ = 2'd0,
    NXT_BTB = 2'd1,
    NXT_RAS = 2'd2
  } frs_nxt_src_e;
endpackage

// File: rtl/frs_branch_scan.sv
// Finds the lowest and second-lowest control-flow slots at or after the start slot.
module frs_branch_scan #(
  parameter int SLOTS = 16,
  parameter int IDX_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] ctl_slots,
  input  logic [IDX_W-1:0] start_idx,
  output logic             first_found,
  output logic [IDX_W-1:0] first_idx,
  output logic             second_found,
  output logic [IDX_W-1:0] second_idx
);
  always_comb begin
    first_found  = 1'b0;
    first_idx    = '0;
    second_found = 1'b0;
    second_idx   = '0;
    // Walk downward: every newly found lower slot pushes the old first to second.
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (ctl_slots[i] && (i >= int'(start_idx))) begin
        second_found = first_found;
        second_idx   = first_idx;
        first_found  = 1'b1;
        first_idx    = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/frs_run_len.sv
// Turns start slot, cap and closing branch into a run length and slot mask.
module frs_run_len #(
  parameter int SLOTS   = 16,
  parameter int MAX_RUN = 12,
  parameter int IDX_W   = $clog2(SLOTS),
  parameter int CNT_W   = $clog2(MAX_RUN + 1)
) (
  input  logic [IDX_W-1:0] start_idx,
  input  logic [CNT_W-1:0] cfg_max,
  input  logic             term_found,
  input  logic [IDX_W-1:0] term_idx,
  output logic             term_in_run,
  output logic [CNT_W-1:0] run_len,
  output logic [SLOTS-1:0] run_mask
);
  localparam int LW = ((CNT_W > IDX_W + 1) ? CNT_W : IDX_W + 1) + 1;

  logic [LW-1:0] eff_cap;
  logic [LW-1:0] line_rem;
  logic [LW-1:0] cap;
  logic [LW-1:0] term_dist;
  logic [LW-1:0] len_w;

  always_comb begin
    if ((cfg_max == '0) || (cfg_max > CNT_W'(MAX_RUN))) eff_cap = LW'(MAX_RUN);
    else                                                 eff_cap = LW'(cfg_max);
    line_rem    = LW'(SLOTS) - LW'(start_idx);
    cap         = (eff_cap < line_rem) ? eff_cap : line_rem;
    term_dist   = LW'(term_idx) - LW'(start_idx) + LW'(1);
    term_in_run = term_found && (term_dist <= cap);
    len_w       = term_in_run ? term_dist : cap;
    run_len     = CNT_W'(len_w);
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_mask
    assign run_mask[g] = (LW'(g) >= LW'(start_idx)) &&
                         (LW'(g) < (LW'(start_idx) + len_w));
  end
endmodule

// File: rtl/frs_next_pc.sv
// Picks the next fetch address: link stack, then target buffer, then sequential.
module frs_next_pc
  import frs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              redirect,
  input  logic              term_is_ret,
  input  logic              ras_valid,
  input  logic [ADDR_W-1:0] ras_addr,
  input  logic              btb_hit,
  input  logic [ADDR_W-1:0] btb_target,
  input  logic [ADDR_W-1:0] seq_addr,
  output logic [ADDR_W-1:0] next_addr
);
  frs_nxt_src_e src;

  always_comb begin
    src = NXT_SEQ;
    if (redirect) begin
      if (term_is_ret && ras_valid) src = NXT_RAS;
      else if (btb_hit)             src = NXT_BTB;
    end
    unique case (src)
      NXT_RAS: next_addr = ras_addr;
      NXT_BTB: next_addr = btb_target;
      default: next_addr = seq_addr;
    endcase
  end
endmodule

// File: rtl/fetch_run_sel.sv
module fetch_run_sel #(
  parameter int ADDR_W      = 32,
  parameter int SLOTS       = 16,
  parameter int MAX_RUN     = 12,
  parameter int INSTR_BYTES = 4,
  localparam int IDX_W      = $clog2(SLOTS),
  localparam int CNT_W      = $clog2(MAX_RUN + 1),
  localparam int OFF_LSB    = $clog2(INSTR_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic [SLOTS-1:0]  pd_branch,
  input  logic [SLOTS-1:0]  pd_uncond,
  input  logic [SLOTS-1:0]  pd_return,
  input  logic [CNT_W-1:0]  max_run,
  input  logic              dir1_taken,
  input  logic              pred2_taken,
  input  logic              btb_hit,
  input  logic [ADDR_W-1:0] btb_target,
  input  logic              ras_valid,
  input  logic [ADDR_W-1:0] ras_addr,
  output logic              out_valid,
  output logic [SLOTS-1:0]  out_mask,
  output logic [CNT_W-1:0]  out_count,
  output logic [ADDR_W-1:0] out_next_addr
);
  logic [SLOTS-1:0]  ctl_slots;
  logic [IDX_W-1:0]  start_idx;
  logic              b1_found, b2_found;
  logic [IDX_W-1:0]  b1_idx, b2_idx;
  logic              b1_taken, b2_taken;
  logic              term_found, term_taken, term_is_ret, term_in_run;
  logic [IDX_W-1:0]  term_idx;
  logic [CNT_W-1:0]  run_len;
  logic [SLOTS-1:0]  run_mask;
  logic [ADDR_W-1:0] seq_addr, sel_addr;

  assign ctl_slots = pd_branch | pd_uncond | pd_return;
  assign start_idx = fetch_addr[OFF_LSB +: IDX_W];

  frs_branch_scan #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_scan (
    .ctl_slots    (ctl_slots),
    .start_idx    (start_idx),
    .first_found  (b1_found),
    .first_idx    (b1_idx),
    .second_found (b2_found),
    .second_idx   (b2_idx)
  );

  // First branch: direction only. Second branch: full prediction, always closes.
  always_comb begin
    b1_taken    = dir1_taken  | pd_uncond[b1_idx] | pd_return[b1_idx];
    b2_taken    = pred2_taken | pd_uncond[b2_idx] | pd_return[b2_idx];
    term_found  = 1'b0;
    term_idx    = b2_idx;
    term_taken  = 1'b0;
    if (b1_found && b1_taken) begin
      term_found = 1'b1;
      term_idx   = b1_idx;
      term_taken = 1'b1;
    end else if (b2_found) begin
      term_found = 1'b1;
      term_idx   = b2_idx;
      term_taken = b2_taken;
    end
    term_is_ret = pd_return[term_idx];
  end

  frs_run_len #(.SLOTS(SLOTS), .MAX_RUN(MAX_RUN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_len (
    .start_idx   (start_idx),
    .cfg_max     (max_run),
    .term_found  (term_found),
    .term_idx    (term_idx),
    .term_in_run (term_in_run),
    .run_len     (run_len),
    .run_mask    (run_mask)
  );

  assign seq_addr = (fetch_addr & ~ADDR_W'(INSTR_BYTES - 1))
                  + (ADDR_W'(run_len) << OFF_LSB);

  frs_next_pc #(.ADDR_W(ADDR_W)) u_npc (
    .redirect    (term_in_run && term_taken),
    .term_is_ret (term_is_ret),
    .ras_valid   (ras_valid),
    .ras_addr    (ras_addr),
    .btb_hit     (btb_hit),
    .btb_target  (btb_target),
    .seq_addr    (seq_addr),
    .next_addr   (sel_addr)
  );

  // Next-state logic with explicit clock enable on the data registers.
  logic              valid_d;
  logic [SLOTS-1:0]  mask_d;
  logic [CNT_W-1:0]  count_d;
  logic [ADDR_W-1:0] next_d;
  logic              data_en;

  always_comb begin
    valid_d = req_valid;
    data_en = req_valid;
    mask_d  = run_mask;
    count_d = run_len;
    next_d  = sel_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_mask      <= '0;
      out_count     <= '0;
      out_next_addr <= '0;
    end else begin
      out_valid <= valid_d;
      if (data_en) begin
        out_mask      <= mask_d;
        out_count     <= count_d;
        out_next_addr <= next_d;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(out_count) && $stable(out_next_addr) && $stable(out_mask))); // R2
  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_count != '0) && (out_count <= CNT_W'(MAX_RUN)))); // R4
  AST_MASK_POP: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_mask) == int'(out_count))); // R11
  AST_MASK_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_mask ^ (out_mask << 1)) <= 2)); // R11
endmodule

// File: tb/fetch_run_sel_tb_top.sv
module fetch_run_sel_tb_top;
  localparam int AW    = 32;
  localparam int NS    = 16;
  localparam int MR    = 12;
  localparam int CW    = 4;
  localparam logic [AW-1:0] BASE = 32'h0000_1000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] fetch_addr;
  logic [NS-1:0] pd_branch, pd_uncond, pd_return;
  logic [CW-1:0] max_run;
  logic          dir1_taken, pred2_taken, btb_hit, ras_valid;
  logic [AW-1:0] btb_target, ras_addr;
  logic          out_valid;
  logic [NS-1:0] out_mask;
  logic [CW-1:0] out_count;
  logic [AW-1:0] out_next_addr;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  fetch_run_sel dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fetch_addr(fetch_addr),
    .pd_branch(pd_branch), .pd_uncond(pd_uncond), .pd_return(pd_return),
    .max_run(max_run), .dir1_taken(dir1_taken), .pred2_taken(pred2_taken),
    .btb_hit(btb_hit), .btb_target(btb_target), .ras_valid(ras_valid),
    .ras_addr(ras_addr), .out_valid(out_valid), .out_mask(out_mask),
    .out_count(out_count), .out_next_addr(out_next_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Behavioural model: walk the slots one by one from the start slot.
  task automatic model(output logic [NS-1:0] e_mask, output int e_cnt,
                       output logic [AW-1:0] e_next);
    int s, lim, n, nb;
    bit redirect, is_ret, stop;
    logic [AW-1:0] seq;
    s   = int'(fetch_addr[5:2]);
    lim = (max_run == 0 || int'(max_run) > MR) ? MR : int'(max_run);
    n = 0; nb = 0; redirect = 0; is_ret = 0; stop = 0; e_mask = '0;
    for (int i = s; i < NS; i++) begin
      if (!stop) begin
        if (n == lim) stop = 1;
        else begin
          e_mask[i] = 1'b1;
          n++;
          if (pd_branch[i] | pd_uncond[i] | pd_return[i]) begin
            nb++;
            if (nb == 1 && (dir1_taken || pd_uncond[i] || pd_return[i])) begin
              redirect = 1; is_ret = pd_return[i]; stop = 1;
            end else if (nb == 2) begin
              redirect = pred2_taken || pd_uncond[i] || pd_return[i];
              is_ret = pd_return[i]; stop = 1;
            end
          end
        end
      end
    end
    seq    = {fetch_addr[AW-1:2], 2'b00} + AW'(n * 4);
    e_cnt  = n;
    if (!redirect)              e_next = seq;
    else if (is_ret && ras_valid) e_next = ras_addr;
    else if (btb_hit)           e_next = btb_target;
    else                        e_next = seq;
  endtask

  // Inputs already set at a negedge; result is sampled at the following negedge.
  task automatic step(input string tag);
    logic [NS-1:0] em; int ec; logic [AW-1:0] en;
    req_valid = 1'b1;
    model(em, ec, en);
    @(negedge clk);
    chk(out_valid === 1'b1, "R2 valid", AW'(out_valid), 1);
    chk(out_count === CW'(ec), {tag, " count"}, AW'(out_count), AW'(ec));
    chk(out_next_addr === en, {tag, " next"}, out_next_addr, en);
    chk(out_mask === em, "R11 mask", AW'(out_mask), AW'(em));
  endtask

  task automatic idle_step();
    logic [NS-1:0] pm; logic [CW-1:0] pc; logic [AW-1:0] pn;
    pm = out_mask; pc = out_count; pn = out_next_addr;
    req_valid = 1'b0;
    fetch_addr = BASE + 32'd4; pd_branch = 16'h0002; dir1_taken = 1'b1;
    btb_hit = 1'b1; btb_target = 32'hDEAD_0000;
    @(negedge clk);
    chk(out_valid === 1'b0, "R2 idle valid", AW'(out_valid), 0);
    chk(out_count === pc && out_mask === pm, "R2 idle hold count", AW'(out_count), AW'(pc));
    chk(out_next_addr === pn, "R2 idle hold next", out_next_addr, pn);
  endtask

  task automatic clr(input int slot, input int mr);
    fetch_addr = BASE + AW'(slot * 4);
    max_run = CW'(mr);
    pd_branch = '0; pd_uncond = '0; pd_return = '0;
    dir1_taken = 0; pred2_taken = 0; btb_hit = 0; ras_valid = 0;
    btb_target = 32'h0000_8000; ras_addr = 32'h0000_C000;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0;
    clr(0, 0);
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1 valid", AW'(out_valid), 0);
    chk(out_mask === '0 && out_count === '0, "R1 mask/count", AW'(out_count), 0);
    chk(out_next_addr === '0, "R1 next", out_next_addr, 0);
    rst_n = 1'b1;

    clr(0, 0);   step("R3 R4 no branch cap");
    clr(10, 12); step("R3 line end");
    clr(0, 5);   step("R4 cap five");
    clr(0, 14);  step("R4 cap above max");
    idle_step();
    clr(0, 12); pd_branch[2] = 1; step("R5 first not-taken");
    clr(0, 12); pd_branch[2] = 1; dir1_taken = 1; btb_hit = 1; step("R6 first taken");
    clr(3, 12); pd_uncond[4] = 1; btb_hit = 1; step("R6 uncond first");
    clr(0, 12); pd_branch[2] = 1; pd_branch[5] = 1; pred2_taken = 1; btb_hit = 1;
    step("R7 second taken");
    clr(0, 12); pd_branch[2] = 1; pd_branch[5] = 1; step("R7 second not-taken");
    clr(0, 12); pd_branch[2] = 1; pd_branch[9] = 1; pd_branch[11] = 1; pred2_taken = 1;
    step("R7 third ignored");
    clr(0, 12); pd_branch[1] = 1; pd_return[6] = 1; btb_hit = 1; ras_valid = 1;
    step("R8 second return ras");
    clr(0, 12); pd_branch[1] = 1; pd_return[6] = 1; btb_hit = 1; step("R8 return btb");
    clr(0, 12); pd_branch[4] = 1; dir1_taken = 1; ras_valid = 1; btb_hit = 1;
    step("R8 non-return ignores ras");
    clr(0, 12); pd_branch[4] = 1; dir1_taken = 1; step("R9 btb miss");
    clr(0, 12); pd_return[7] = 1; step("R9 return no target");
    clr(0, 3);  pd_uncond[3] = 1; btb_hit = 1; step("R10 beyond cap");
    clr(0, 3);  pd_branch[2] = 1; pd_branch[3] = 1; pred2_taken = 1; btb_hit = 1;
    step("R10 second beyond cap");
    clr(6, 12); pd_uncond[3] = 1; btb_hit = 1; step("R10 before start");
    clr(15, 12); pd_branch[15] = 1; dir1_taken = 1; btb_hit = 1; step("R6 last slot");
    idle_step();

    for (int k = 0; k < 3000; k++) begin
      logic [NS-1:0] r1, r2;
      fetch_addr = $urandom();
      max_run    = CW'($urandom_range(0, 15));
      r1 = NS'($urandom()); r2 = NS'($urandom());
      pd_branch  = r1 & r2 & NS'($urandom());
      pd_uncond  = r1 & r2 & ~pd_branch & NS'($urandom()) & NS'($urandom());
      pd_return  = r1 & ~r2 & NS'($urandom()) & NS'($urandom()) & NS'($urandom());
      dir1_taken = $urandom_range(0, 1) == 1;
      pred2_taken = $urandom_range(0, 1) == 1;
      btb_hit    = $urandom_range(0, 3) != 0;
      ras_valid  = $urandom_range(0, 1) == 1;
      btb_target = $urandom();
      ras_addr   = $urandom();
      if (k % 97 == 0) idle_step();
      else step("R3 R5 R6 R7 R8 R9 R10 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule